// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports exactly one of three relations: less-than, equal or greater-than. It is built from identical narrow slices. Each slice resolves its own pair of nibbles from the top bit downward. It then folds in the verdict handed up by the slice below it through three cascade lines. A difference found in a higher slice always overrides whatever the lower slices concluded. Only when a slice sees equal nibbles does it pass the lower verdict upward unchanged.

The top module chains `NUM_SLICES` slices of `SLICE_W` bits each, which by default gives a 12-bit comparison. The lowest slice takes its cascade lines from the block's ports. Driving them with the "equal" pattern (less 0, equal 1, greater 0) gives a plain comparison of the full words. Driving them with a different pattern lets a further, less significant comparator be chained underneath. The logic is purely combinational and has no clock or reset.

Top module: `mag_cmp_chain`

## Requirements
- R1: When A equals B, `eq_o` equals `casc_eq_i`. Whenever A differs from B, `eq_o` is 0.
- R2: When A is greater than B as unsigned values, `gt_o` is 1. When A equals B, `gt_o` equals `casc_gt_i`.
- R3: When A is less than B as unsigned values, `lt_o` is 1. When A equals B, `lt_o` equals `casc_lt_i`.
- R4: A difference in a more significant slice decides the outputs, regardless of any contrary difference in the less significant slices.
- R5: With the cascade inputs at less 0, equal 1, greater 0, the outputs match an unsigned comparison of the full `DATA_W`-bit words.
- R6: Whenever exactly one cascade input is 1, exactly one of `lt_o`, `eq_o` and `gt_o` is 1.
- R7: When A differs from B, the cascade inputs have no effect on any output.
- R8: When A equals B and all three cascade inputs are 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W (12) | First unsigned operand |
| b_i | input | DATA_W (12) | Second unsigned operand |
| casc_lt_i | input | 1 | Less-than verdict from a lower-order stage |
| casc_eq_i | input | 1 | Equal verdict from a lower-order stage |
| casc_gt_i | input | 1 | Greater-than verdict from a lower-order stage |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A is greater than B |

## Verification
The hardest case to reach from the ports is the top slice forwarding a verdict that was decided deep in the chain. Random operands almost never agree in their upper slices, so the lowest slice and the cascade inputs are seldom consulted. The stimulus therefore picks one slice at a time. It forces every bit above that slice to match, sweeps both nibbles of the slice through all 256 pairs, and leaves the bits below random, so that lower-slice differences must be overridden. Every one of these vectors is repeated under all eight cascade patterns. A final group of boundary pairs (zero, all-ones, the midpoint, and neighbours of each) is also run under every cascade pattern.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

   // Three-way verdict; one-hot when meaningful
   typedef struct packed {
      logic lt;
      logic eq;
      logic gt;
   } cmp_res_t;

   localparam cmp_res_t RES_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/mag_cmp_scan.sv
// Local comparison of one slice, resolved from the top bit downward.
module mag_cmp_scan
   import mag_cmp_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output cmp_res_t     res_o
);

   // prefix chain: index k covers bits W-1 down to k
   logic [W:0] same_q;
   logic [W:0] above_q;

   assign same_q[W]  = 1'b1;
   assign above_q[W] = 1'b0;

   for (genvar i = W - 1; i >= 0; i--) begin : g_bit
      assign same_q[i]  = same_q[i+1] & ~(a_i[i] ^ b_i[i]);
      assign above_q[i] = above_q[i+1] | (same_q[i+1] & a_i[i] & ~b_i[i]);
   end

   assign res_o.eq = same_q[0];
   assign res_o.gt = above_q[0];
   assign res_o.lt = ~same_q[0] & ~above_q[0];

endmodule

// File: rtl/mag_cmp_merge.sv
// Folds a lower-order verdict under the local verdict.
module mag_cmp_merge
   import mag_cmp_pkg::*;
(
   input  cmp_res_t local_i,
   input  cmp_res_t lower_i,
   output cmp_res_t res_o
);

   assign res_o.gt = local_i.gt | (local_i.eq & lower_i.gt);
   assign res_o.lt = local_i.lt | (local_i.eq & lower_i.lt);
   assign res_o.eq = local_i.eq & lower_i.eq;

endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
   import mag_cmp_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  cmp_res_t     casc_i,
   output cmp_res_t     casc_o
);

   cmp_res_t local_res;

   mag_cmp_scan #(.W(W)) scan_i (
      .a_i  (a_i),
      .b_i  (b_i),
      .res_o(local_res)
   );

   mag_cmp_merge merge_i (
      .local_i(local_res),
      .lower_i(casc_i),
      .res_o  (casc_o)
   );

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
   import mag_cmp_pkg::*;
#(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 3,
   localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              casc_lt_i,
   input  logic              casc_eq_i,
   input  logic              casc_gt_i,
   output logic              lt_o,
   output logic              eq_o,
   output logic              gt_o
);

   if (SLICE_W < 1) begin : g_bad_slice_w
      $error("mag_cmp_chain: SLICE_W must be at least 1");
   end
   if (NUM_SLICES < 1) begin : g_bad_num_slices
      $error("mag_cmp_chain: NUM_SLICES must be at least 1");
   end

   // link[0] enters the least significant slice
   cmp_res_t link [NUM_SLICES+1];

   assign link[0] = '{lt: casc_lt_i, eq: casc_eq_i, gt: casc_gt_i};

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      mag_cmp_slice #(.W(SLICE_W)) slice_i (
         .a_i   (a_i[s*SLICE_W +: SLICE_W]),
         .b_i   (b_i[s*SLICE_W +: SLICE_W]),
         .casc_i(link[s]),
         .casc_o(link[s+1])
      );
   end

   assign lt_o = link[NUM_SLICES].lt;
   assign eq_o = link[NUM_SLICES].eq;
   assign gt_o = link[NUM_SLICES].gt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
   parameter int DATA_W = 12
) (
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              casc_lt_i,
   input logic              casc_eq_i,
   input logic              casc_gt_i,
   input logic              lt_o,
   input logic              eq_o,
   input logic              gt_o
);

   always_comb begin
      // R6: single cascade verdict in gives single verdict out
      if ($countones({casc_lt_i, casc_eq_i, casc_gt_i}) == 1)
         a_r6_single_out: assert ($countones({lt_o, eq_o, gt_o}) == 1);
      // R1: equal output only for matching words with equal cascade
      if (eq_o)
         a_r1_eq_needs_match: assert (a_i == b_i && casc_eq_i);
      // R2, R7: greater words override cascade
      if (a_i > b_i)
         a_r2_gt_wins: assert (gt_o && !lt_o && !eq_o);
      // R3, R7: smaller words override cascade
      if (a_i < b_i)
         a_r3_lt_wins: assert (lt_o && !gt_o && !eq_o);
      // R8: equal words forward the cascade verdict unchanged
      if (a_i == b_i)
         a_r8_forward: assert (lt_o == casc_lt_i && eq_o == casc_eq_i
                               && gt_o == casc_gt_i);
   end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.DATA_W(DATA_W)) chk_i (
   .a_i      (a_i),
   .b_i      (b_i),
   .casc_lt_i(casc_lt_i),
   .casc_eq_i(casc_eq_i),
   .casc_gt_i(casc_gt_i),
   .lt_o     (lt_o),
   .eq_o     (eq_o),
   .gt_o     (gt_o)
);

// File: tb/mag_cmp_chain_tb_top.sv
`timescale 1ns/1ps
module mag_cmp_chain_tb_top;

   localparam int SW = 4;
   localparam int NS = 3;
   localparam int DW = SW * NS;

   logic          clk = 1'b0;
   logic [DW-1:0] a, b;
   logic          c_lt, c_eq, c_gt;
   logic          lt, eq, gt;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   mag_cmp_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) dut_i (
      .a_i      (a),
      .b_i      (b),
      .casc_lt_i(c_lt),
      .casc_eq_i(c_eq),
      .casc_gt_i(c_gt),
      .lt_o     (lt),
      .eq_o     (eq),
      .gt_o     (gt)
   );

   // cas bits: [2]=lt, [1]=eq, [0]=gt
   task automatic apply(input logic [DW-1:0] av, input logic [DW-1:0] bv,
                        input logic [2:0] cas, input string ctx);
      logic [2:0] exp_v;
      string      tag;
      @(negedge clk);
      a = av; b = bv; {c_lt, c_eq, c_gt} = cas;
      #1;
      if (av > bv) begin
         exp_v = 3'b001; tag = "R2/R7";
      end else if (av < bv) begin
         exp_v = 3'b100; tag = "R3/R7";
      end else begin
         exp_v = cas; tag = (cas == 3'b000) ? "R8" : "R1";
      end
      checks++;
      if ({lt, eq, gt} !== exp_v) begin
         errors++;
         $display("FAIL %s %s a=%h b=%h cas=%b actual=%b expected=%b",
                  tag, ctx, av, bv, cas, {lt, eq, gt}, exp_v);
      end
      if ($countones(cas) == 1) begin
         checks++;
         if ($countones({lt, eq, gt}) != 1) begin
            errors++;
            $display("FAIL R6 a=%h b=%h cas=%b actual=%b expected=onehot",
                     av, bv, cas, {lt, eq, gt});
         end
      end
   endtask

   initial begin
      logic [DW-1:0] bnd [6];
      a = '0; b = '0; {c_lt, c_eq, c_gt} = 3'b010;
      bnd[0] = '0;     bnd[1] = '1;     bnd[2] = 12'h001;
      bnd[3] = 12'hFFE; bnd[4] = 12'h800; bnd[5] = 12'h7FF;

      // idle state with equal cascade: equal verdict (R1)
      apply('0, '0, 3'b010, "R1 idle");

      // R4: per-slice sweep, upper bits matched, lower bits random
      for (int s = 0; s < NS; s++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               for (int c = 0; c < 8; c++) begin
                  logic [DW-1:0] av, bv, lowm;
                  av = DW'($urandom);
                  bv = DW'($urandom);
                  lowm = DW'((1 << (s * SW)) - 1);
                  bv = (bv & lowm) | (av & ~lowm);
                  av[s*SW +: SW] = SW'(x);
                  bv[s*SW +: SW] = SW'(y);
                  if (x == y && (c & 1) == 0) bv = av;
                  apply(av, bv, 3'(c), "R4 slice sweep");
               end
            end
         end
      end

      // R5: random full-width words against plain compare
      for (int n = 0; n < 2500; n++) begin
         logic [DW-1:0] av, bv;
         av = DW'($urandom);
         bv = (n % 5 == 0) ? av : DW'($urandom);
         for (int c = 0; c < 8; c++)
            apply(av, bv, 3'(c), (c == 2) ? "R5 random" : "R7 random");
      end

      // boundary pairs under all cascade patterns (R5, R8)
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            for (int c = 0; c < 8; c++)
               apply(bnd[i], bnd[j], 3'(c), "R5 boundary");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule